// File: doc/BRIEF.md
# Pin-muxed GPIO controller with level-match interrupts

This block is a register-mapped general-purpose I/O controller for fourteen pins. Software reaches it through a simple 32-bit read/write register bus. For each pin, software picks one of two modes. In GPIO mode the pin is driven and sampled under register control. In alternate mode the pin is handed to a fixed on-chip peripheral: a serial port, upper address lines, a debug strobe, two bus request/grant pairs or a messaging interrupt. The controller only routes these signals. The peripherals and the pad cells sit outside it.

Pin inputs pass through a two-flop synchronizer. The synchronized value feeds the data read path, the alternate-function inputs and a per-pin level comparator. When a synchronized pin value equals its programmed level, a sticky status bit latches and stays set until software clears it. The OR of all status bits drives a maskable interrupt line. A separately enabled subset of the status bits drives a non-maskable interrupt line.

Top module: `pin_mux_gpio`

## Requirements
- R1: While reset is asserted, every register reads zero, `pad_oe`, `pad_out`, `irq_o` and `nmi_o` are all zero, and every pin is therefore a GPIO input.
- R2: Word offsets decode as follows:
  - 0x00 is the mode register (1 = alternate function).
  - 0x04 is the direction register (1 = output).
  - 0x08 is the pin data register.
  - 0x0C is the match level register.
  - 0x10 is the status register.
  - 0x14 is the non-maskable enable register.

  Writes to the mode, direction, level and enable registers read back with bits 31:14 as zero. Any other offset reads zero.
- R3: For a pin in GPIO mode, `pad_oe` equals that pin's direction bit and `pad_out` equals the bit last written to offset 0x08.
- R4: Reading offset 0x08 returns `pad_in` after two clock edges of synchronization. A change made before an edge is not visible after one edge, and is visible after the second.
- R5: For a pin in alternate mode, `pad_oe` is fixed by the function and the direction bit is ignored.
  - Output pins: 0 (serial TX), 2 (RTS), 4–7 (address bits 22–25), 8 (debug), 10 (grant 4), 12 (grant 5) and 13 (messaging interrupt). These drive `pad_out` from the matching peripheral input port.
  - Input pins: 1, 3, 9 and 11.
- R6: The synchronized values of pins 1, 3, 9 and 11 appear on `uart_rx_o`, `uart_cts_o`, `pci_req4_o` and `pci_req5_o`.
- R7: Status bit x sets on the clock edge after the synchronized pin x value equals level bit x. Once set, it stays set while no write to offset 0x10 occurs.
- R8: A write to offset 0x10 clears each status bit written as 0 and keeps each bit written as 1. If a clear and a set of the same bit fall in the same cycle, the bit remains set.
- R9: `irq_o` is the OR of all status bits. `nmi_o` is the OR of the status bits ANDed with the non-maskable enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 14 | Values sampled from the pads |
| pad_out | output | 14 | Values driven to the pads |
| pad_oe | output | 14 | Pad output enables |
| uart_tx_i | input | 1 | Serial transmit data for pin 0 |
| uart_rts_i | input | 1 | Request-to-send for pin 2 |
| addr_hi_i | input | 4 | Address bits 22–25 for pins 4–7 |
| dbg_i | input | 1 | Debug strobe for pin 8 |
| pci_gnt4_i | input | 1 | Grant 4 for pin 10 |
| pci_gnt5_i | input | 1 | Grant 5 for pin 12 |
| pci_msgint_i | input | 1 | Messaging interrupt for pin 13 |
| uart_rx_o | output | 1 | Synchronized pin 1 |
| uart_cts_o | output | 1 | Synchronized pin 3 |
| pci_req4_o | output | 1 | Synchronized pin 9 |
| pci_req5_o | output | 1 | Synchronized pin 11 |
| irq_o | output | 1 | Maskable interrupt |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
Register writes and the pad mux outputs are due on the edge that completes the bus cycle. Data reads and the alternate-function inputs follow a pad change after two edges. A status bit, and `irq_o` or `nmi_o` with it, follows a pad change after three edges. The bench drives every stimulus on a falling edge and counts rising edges to each result. For the pad-driven results, it checks on the falling edge one edge early that nothing has changed yet, and on the due falling edge that the new value has arrived. Bus reads are combinational and are sampled shortly after the address settles, mid-cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [2:0] {
      REG_MODE  = 3'd0,
      REG_DIR   = 3'd1,
      REG_DATA  = 3'd2,
      REG_LEVEL = 3'd3,
      REG_STAT  = 3'd4,
      REG_NMIEN = 3'd5
   } reg_idx_e;

   // Fixed direction of each alternate function, 1 = drives the pad
   localparam logic [13:0] ALT_DRIVES = 14'h35F5;
   localparam int unsigned PIN_COUNT  = 14;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 14,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync needs at least two stages");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[s] <= '0;
         end else if (s == 0) begin
            chain_q[s] <= d_i;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int unsigned NUM_PINS = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  reg_idx_e            idx,
   input  logic                idx_ok,
   input  logic [NUM_PINS-1:0] wdata,
   input  logic [NUM_PINS-1:0] pin_val,
   output logic [NUM_PINS-1:0] mode_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] dout_q,
   output logic [NUM_PINS-1:0] level_q,
   output logic [NUM_PINS-1:0] stat_q,
   output logic [NUM_PINS-1:0] nmien_q,
   output logic [NUM_PINS-1:0] rdata
);
   logic                wr_ok;
   logic                stat_wr;
   logic [NUM_PINS-1:0] match;

   assign wr_ok   = wr_en && idx_ok;
   assign stat_wr = wr_ok && (idx == REG_STAT);
   assign match   = ~(pin_val ^ level_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         dir_q   <= '0;
         dout_q  <= '0;
         level_q <= '0;
         nmien_q <= '0;
      end else if (wr_ok) begin
         case (idx)
            REG_MODE:  mode_q  <= wdata;
            REG_DIR:   dir_q   <= wdata;
            REG_DATA:  dout_q  <= wdata;
            REG_LEVEL: level_q <= wdata;
            REG_NMIEN: nmien_q <= wdata;
            default:   ;
         endcase
      end
   end

   // Sticky status: write-0 clears, a new match always wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else begin
         stat_q <= (stat_wr ? (stat_q & wdata) : stat_q) | match;
      end
   end

   always_comb begin
      rdata = '0;
      if (idx_ok) begin
         case (idx)
            REG_MODE:  rdata = mode_q;
            REG_DIR:   rdata = dir_q;
            REG_DATA:  rdata = pin_val;
            REG_LEVEL: rdata = level_q;
            REG_STAT:  rdata = stat_q;
            REG_NMIEN: rdata = nmien_q;
            default:   rdata = '0;
         endcase
      end
   end

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   p_match_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (match != '0) |=> ((stat_q & $past(match)) == $past(match)));

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> ((stat_q & ~($past(wdata) | $past(match))) == '0));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
   parameter int unsigned   NUM_PINS  = 14,
   parameter logic [NUM_PINS-1:0] ALT_DIR = '0
) (
   input  logic [NUM_PINS-1:0] mode_i,
   input  logic [NUM_PINS-1:0] dir_i,
   input  logic [NUM_PINS-1:0] dout_i,
   input  logic [NUM_PINS-1:0] alt_src_i,
   output logic [NUM_PINS-1:0] pad_out_o,
   output logic [NUM_PINS-1:0] pad_oe_o
);
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      if (ALT_DIR[p]) begin : g_alt_out
         assign pad_out_o[p] = mode_i[p] ? alt_src_i[p] : dout_i[p];
         assign pad_oe_o[p]  = mode_i[p] | dir_i[p];
      end else begin : g_alt_in
         assign pad_out_o[p] = mode_i[p] ? 1'b0 : dout_i[p];
         assign pad_oe_o[p]  = ~mode_i[p] & dir_i[p];
      end
   end
endmodule

// File: rtl/pin_mux_gpio.sv
module pin_mux_gpio
   import gpio_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 14,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   input  logic                uart_tx_i,
   input  logic                uart_rts_i,
   input  logic [3:0]          addr_hi_i,
   input  logic                dbg_i,
   input  logic                pci_gnt4_i,
   input  logic                pci_gnt5_i,
   input  logic                pci_msgint_i,
   output logic                uart_rx_o,
   output logic                uart_cts_o,
   output logic                pci_req4_o,
   output logic                pci_req5_o,
   output logic                irq_o,
   output logic                nmi_o
);
   localparam int unsigned WORD_LSB = 2;
   localparam int unsigned IDX_W    = ADDR_W - WORD_LSB;

   if (NUM_PINS != PIN_COUNT) begin : g_bad_pins
      $error("alternate function map is fixed at 14 pins");
   end
   if (DATA_W < NUM_PINS || ADDR_W < 5) begin : g_bad_bus
      $error("bus too narrow for the register map");
   end

   logic [NUM_PINS-1:0] pin_sync, mode_q, dir_q, dout_q, level_q, stat_q, nmien_q;
   logic [NUM_PINS-1:0] rd_val, alt_src;
   logic [IDX_W-1:0]    word_idx;
   logic                idx_ok;
   reg_idx_e            idx;
   logic                unused_bits;

   assign word_idx    = bus_addr[ADDR_W-1:WORD_LSB];
   assign idx_ok      = (word_idx <= IDX_W'(REG_NMIEN));
   assign idx         = reg_idx_e'(word_idx[2:0]);
   assign unused_bits = ^{bus_wdata[DATA_W-1:NUM_PINS], bus_addr[WORD_LSB-1:0]};

   gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_i(pad_in), .q_o(pin_sync));

   gpio_regs #(.NUM_PINS(NUM_PINS)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_sel && bus_wr), .idx(idx),
      .idx_ok(idx_ok), .wdata(bus_wdata[NUM_PINS-1:0]), .pin_val(pin_sync),
      .mode_q(mode_q), .dir_q(dir_q), .dout_q(dout_q), .level_q(level_q),
      .stat_q(stat_q), .nmien_q(nmien_q), .rdata(rd_val));

   always_comb begin
      alt_src     = '0;
      alt_src[0]  = uart_tx_i;
      alt_src[2]  = uart_rts_i;
      alt_src[7:4] = addr_hi_i;
      alt_src[8]  = dbg_i;
      alt_src[10] = pci_gnt4_i;
      alt_src[12] = pci_gnt5_i;
      alt_src[13] = pci_msgint_i;
   end

   gpio_pad_mux #(.NUM_PINS(NUM_PINS), .ALT_DIR(ALT_DRIVES)) mux_i (
      .mode_i(mode_q), .dir_i(dir_q), .dout_i(dout_q), .alt_src_i(alt_src),
      .pad_out_o(pad_out), .pad_oe_o(pad_oe));

   assign bus_rdata  = {{(DATA_W-NUM_PINS){1'b0}}, rd_val};
   assign uart_rx_o  = pin_sync[1];
   assign uart_cts_o = pin_sync[3];
   assign pci_req4_o = pin_sync[9];
   assign pci_req5_o = pin_sync[11];
   assign irq_o      = |stat_q;
   assign nmi_o      = |(stat_q & nmien_q);

   p_alt_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & mode_q) == (ALT_DRIVES & mode_q)));

   p_gpio_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~mode_q) == (dir_q & ~mode_q)));

   p_nmi_in_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |-> irq_o);

   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[DATA_W-1:NUM_PINS] == '0));
endmodule

// File: tb/pin_mux_gpio_tb.sv
module pin_mux_gpio_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [13:0] pad_in = '0, pad_out, pad_oe;
   logic        uart_tx_i = 0, uart_rts_i = 0, dbg_i = 0;
   logic        pci_gnt4_i = 0, pci_gnt5_i = 0, pci_msgint_i = 0;
   logic [3:0]  addr_hi_i = '0;
   logic        uart_rx_o, uart_cts_o, pci_req4_o, pci_req5_o, irq_o, nmi_o;

   int checks = 0, failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_mux_gpio dut_i (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 pad_oe", {18'd0, pad_oe}, 0);
      check("R1 pad_out", {18'd0, pad_out}, 0);
      check("R1 irq/nmi", {30'd0, irq_o, nmi_o}, 0);
      for (int i = 0; i < 6; i++) begin
         rd(5'(i*4), v);
         check("R1 reg zero", v, 0);
      end
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(5'h00, 32'hFFFF_FFFF); @(negedge clk); rd(5'h00, v); check("R2 mode", v, 32'h3FFF);
      wr(5'h04, 32'hA5A5_1234); @(negedge clk); rd(5'h04, v); check("R2 dir", v, 32'h1234);
      wr(5'h0C, 32'hFFFF_C001); @(negedge clk); rd(5'h0C, v); check("R2 level", v, 32'h0001);
      wr(5'h14, 32'h0000_2AAA); @(negedge clk); rd(5'h14, v); check("R2 nmien", v, 32'h2AAA);
      rd(5'h18, v); check("R2 unmapped", v, 0);
      wr(5'h00, 0); wr(5'h04, 0); wr(5'h0C, 0); wr(5'h14, 0);
   endtask

   task automatic t_gpio_out();
      wr(5'h04, 32'h00FF);
      wr(5'h08, 32'h1234);
      check("R3 oe", {18'd0, pad_oe}, 32'h00FF);
      check("R3 out", {18'd0, pad_out}, 32'h1234);
   endtask

   task automatic t_sync();
      logic [31:0] v;
      @(negedge clk); pad_in = 14'h2A5A;
      @(negedge clk); rd(5'h08, v); check("R4 one edge", v, 0);
      @(negedge clk); rd(5'h08, v); check("R4 two edges", v, 32'h2A5A);
      pad_in = 0; repeat (3) @(negedge clk);
   endtask

   task automatic t_alt();
      logic [13:0] exp;
      uart_tx_i = 1; uart_rts_i = 0; addr_hi_i = 4'b1010; dbg_i = 1;
      pci_gnt4_i = 0; pci_gnt5_i = 1; pci_msgint_i = 1;
      wr(5'h04, 0); wr(5'h08, 32'h3FFF); wr(5'h00, 32'h3FFF);
      exp = '0; exp[0] = uart_tx_i; exp[2] = uart_rts_i; exp[7:4] = addr_hi_i;
      exp[8] = dbg_i; exp[10] = pci_gnt4_i; exp[12] = pci_gnt5_i; exp[13] = pci_msgint_i;
      check("R5 alt oe", {18'd0, pad_oe}, 32'h35F5);
      check("R5 alt out", {18'd0, pad_out}, {18'd0, exp});
      wr(5'h04, 32'h3FFF);
      check("R5 dir ignored", {18'd0, pad_oe}, 32'h35F5);
      pad_in = 14'h0A0A;
      @(negedge clk);
      check("R6 not yet", {28'd0, uart_rx_o, uart_cts_o, pci_req4_o, pci_req5_o}, 0);
      @(negedge clk);
      check("R6 alt inputs", {28'd0, uart_rx_o, uart_cts_o, pci_req4_o, pci_req5_o}, 32'hF);
      pad_in = 0; wr(5'h00, 0); wr(5'h04, 0); wr(5'h08, 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_status();
      logic [31:0] v;
      wr(5'h0C, 32'h3FFF); wr(5'h10, 0);
      @(negedge clk); rd(5'h10, v); check("R8 cleared", v, 0);
      check("R9 irq low", {31'd0, irq_o}, 0);
      pad_in = 14'h0005;
      @(negedge clk); @(negedge clk); rd(5'h10, v);
      check("R7 not yet", v, 0);
      @(negedge clk); rd(5'h10, v);
      check("R7 set", v, 32'h0005);
      check("R9 irq high", {31'd0, irq_o}, 1);
      pad_in = 0; repeat (4) @(negedge clk); rd(5'h10, v);
      check("R7 sticky", v, 32'h0005);
      wr(5'h10, 32'h0001); rd(5'h10, v); check("R8 keep/clear", v, 32'h0001);
      wr(5'h10, 32'h3FFE); rd(5'h10, v); check("R8 write0 clears", v, 0);
      pad_in = 14'h0010; repeat (3) @(negedge clk);
      wr(5'h10, 0); rd(5'h10, v); check("R8 set wins", v, 32'h0010);
      check("R9 nmi masked", {30'd0, irq_o, nmi_o}, 32'h2);
      wr(5'h14, 32'h0010); check("R9 nmi enabled", {31'd0, nmi_o}, 1);
      wr(5'h14, 32'h0020); check("R9 nmi other bit", {31'd0, nmi_o}, 0);
      pad_in = 0; repeat (3) @(negedge clk);
      wr(5'h10, 0); rd(5'h10, v); check("R8 final clear", v, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      t_regs();
      t_gpio_out();
      t_sync();
      t_alt();
      t_status();
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule